// File: doc/BRIEF.md
# Secure-Element Life-Cycle Phase Controller

This block holds the life-cycle phase of a secure chip and decides, cycle by cycle, which privileged operations are open in that phase. The phase moves through six stages: factory test, completion, pre-personalization, personalization, field use and a terminal locked stage. It moves only forward and only one stage at a time. Each step needs a key-verified strobe from an external authentication unit in the same cycle as the request. A terminate request is accepted from every stage and cannot be undone.

At reset, the phase is loaded from a nonvolatile copy presented on `nv_phase_i`, together with a stored flag that records whether the transport key has already been invalidated. The permission outputs are registered and track the phase register. In completion and pre-personalization, the write permissions also need an authenticated session, which opens when a key-verified strobe arrives while the phase stays where it is. Leaving pre-personalization invalidates the transport key for good. From then on, a key strobe can no longer open the file-structure permission.

Top module: `lifecycle_ctrl`

## Requirements
- R1: During reset the phase register loads `nv_phase_i`, using the codes TEST=0, COMP=1, PREP=2, PERS=3, USE=4 and TERM=7. The unused codes 5 and 6 load as TERM.
- R2: An advance request (`adv_req_i`) whose `adv_target_i` equals the current code plus one, with `key_ok_i` high in the same cycle and a current phase of PERS or below, moves `phase_o` to that code on the next clock edge.
- R3: An advance request that names any other target, lacks `key_ok_i`, or arrives in USE or TERM leaves the phase unchanged. It raises `err_o` for exactly the cycle after the request.
- R4: `term_req_i` moves the phase to TERM on the next edge from any phase. It takes priority over a simultaneous advance request and raises no error. TERM is never left.
- R5: `perm_full_mem_o` is high exactly when the phase is TEST. It never returns once TEST is left, not even through a rejected request that targets TEST.
- R6: `perm_os_patch_o` is high only in COMP. It rises one cycle after a `key_ok_i` strobe in a cycle where the phase does not change, and it is cleared whenever the phase changes.
- R7: `perm_file_struct_o` is high only in PREP. It rises after a `key_ok_i` strobe in a cycle where the phase does not change, and only while `tk_void_o` is low.
- R8: `tk_void_o` is set by the step from PREP to PERS and is sticky. At reset it loads `nv_tk_void_i` OR'ed with (loaded phase above PREP). While it is set, a key strobe in PREP leaves `perm_file_struct_o` low.
- R9: `perm_personal_o` is high exactly in PERS, and `perm_use_o` is high exactly in USE.
- R10: In the same cycle that `phase_o` shows TERM, every permission output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the stored phase |
| nv_phase_i | input | 3 | Phase code held in nonvolatile storage |
| nv_tk_void_i | input | 1 | Stored transport-key-invalidated flag |
| adv_req_i | input | 1 | Request to advance the phase |
| adv_target_i | input | 3 | Phase code that the advance request asks for |
| key_ok_i | input | 1 | Key-verified strobe from the authentication unit |
| term_req_i | input | 1 | Request to terminate the chip |
| phase_o | output | 3 | Current phase code |
| tk_void_o | output | 1 | Transport key invalidated (status) |
| err_o | output | 1 | One-cycle pulse for a rejected advance request |
| perm_full_mem_o | output | 1 | Full memory access permitted |
| perm_os_patch_o | output | 1 | OS jump table and patch writes permitted |
| perm_file_struct_o | output | 1 | File structure and static data writes permitted |
| perm_personal_o | output | 1 | Personal data writes permitted |
| perm_use_o | output | 1 | Normal use enabled |

## Verification
The hardest situation to reach is pre-personalization with the transport key already invalidated. The forward-only rule means no legal request path ever returns to that phase once the key is gone. The bench gets there through the reset load instead: it presents a stored PREP code with the stored invalidation flag set, then strobes the key and checks that file-structure access stays closed. It also uses the reset load to reach the unused codes 5 and 6 and the later phases directly. Then it fires terminate together with an advance request to confirm which of the two wins.

// File: rtl/lifecycle_ctrl.sv
module lifecycle_ctrl #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] nv_phase_i,
  input  logic          nv_tk_void_i,
  input  logic          adv_req_i,
  input  logic [PW-1:0] adv_target_i,
  input  logic          key_ok_i,
  input  logic          term_req_i,
  output logic [PW-1:0] phase_o,
  output logic          tk_void_o,
  output logic          err_o,
  output logic          perm_full_mem_o,
  output logic          perm_os_patch_o,
  output logic          perm_file_struct_o,
  output logic          perm_personal_o,
  output logic          perm_use_o
);

  localparam logic [PW-1:0] P_TEST = PW'(0);
  localparam logic [PW-1:0] P_COMP = PW'(1);
  localparam logic [PW-1:0] P_PREP = PW'(2);
  localparam logic [PW-1:0] P_PERS = PW'(3);
  localparam logic [PW-1:0] P_USE  = PW'(4);
  localparam logic [PW-1:0] P_TERM = PW'(7);

  function automatic logic [PW-1:0] load_code(input logic [PW-1:0] c);
    return (c <= P_USE) ? c : P_TERM;
  endfunction

  function automatic logic [4:0] perms(input logic [PW-1:0] p, input logic a);
    return {p == P_TEST, (p == P_COMP) && a, (p == P_PREP) && a,
            p == P_PERS, p == P_USE};
  endfunction

  logic [PW-1:0] ph_q, ph_d, nxt, ld;
  logic          auth_q, auth_d, tk_q, tk_d, err_d;
  logic [4:0]    perm_q;

  assign nxt = ph_q + PW'(1);
  assign ld  = load_code(nv_phase_i);

  always_comb begin
    ph_d  = ph_q;
    tk_d  = tk_q;
    err_d = 1'b0;
    if (term_req_i) begin
      ph_d = P_TERM;
    end else if (adv_req_i) begin
      if (key_ok_i && adv_target_i == nxt && ph_q <= P_PERS) begin
        ph_d = nxt;
        if (ph_q == P_PREP) tk_d = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
    if (ph_d != ph_q)
      auth_d = 1'b0;
    else if (key_ok_i && (ph_q == P_COMP || (ph_q == P_PREP && !tk_q)))
      auth_d = 1'b1;
    else
      auth_d = auth_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= ld;
      auth_q <= 1'b0;
      tk_q   <= nv_tk_void_i | (ld > P_PREP);
      err_o  <= 1'b0;
      perm_q <= perms(ld, 1'b0);
    end else begin
      ph_q   <= ph_d;
      auth_q <= auth_d;
      tk_q   <= tk_d;
      err_o  <= err_d;
      perm_q <= perms(ph_d, auth_d);
    end
  end

  assign phase_o   = ph_q;
  assign tk_void_o = tk_q;
  assign {perm_full_mem_o, perm_os_patch_o, perm_file_struct_o,
          perm_personal_o, perm_use_o} = perm_q;

endmodule

// File: rtl/lifecycle_ctrl_chk.sv
module lifecycle_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase_o,
  input logic       tk_void_o,
  input logic       err_o,
  input logic       perm_full_mem_o,
  input logic       perm_os_patch_o,
  input logic       perm_file_struct_o,
  input logic       perm_personal_o,
  input logic       perm_use_o
);

  assert_forward_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_o >= $past(phase_o));

  assert_term_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 3'd7 |=> phase_o == 3'd7);

  assert_err_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> phase_o == $past(phase_o));

  assert_full_only_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perm_full_mem_o |-> phase_o == 3'd0);

  assert_os_only_comp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    perm_os_patch_o |-> phase_o == 3'd1);

  assert_fs_needs_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_file_struct_o |-> phase_o == 3'd2 && !tk_void_o);

  assert_tk_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tk_void_o |=> tk_void_o);

  assert_pd_use_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_personal_o == (phase_o == 3'd3)) && (perm_use_o == (phase_o == 3'd4)));

  assert_term_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 3'd7 |-> !perm_full_mem_o && !perm_os_patch_o && !perm_file_struct_o
                        && !perm_personal_o && !perm_use_o);

  assert_perm_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({perm_full_mem_o, perm_os_patch_o, perm_file_struct_o,
              perm_personal_o, perm_use_o}));

endmodule

bind lifecycle_ctrl lifecycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_o(phase_o), .tk_void_o(tk_void_o), .err_o(err_o),
  .perm_full_mem_o(perm_full_mem_o), .perm_os_patch_o(perm_os_patch_o),
  .perm_file_struct_o(perm_file_struct_o), .perm_personal_o(perm_personal_o),
  .perm_use_o(perm_use_o)
);

// File: tb/lifecycle_ctrl_tb.sv
module lifecycle_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] nv_phase_i = 3'd0;
  logic       nv_tk_void_i = 1'b0;
  logic       adv_req_i = 1'b0;
  logic [2:0] adv_target_i = 3'd0;
  logic       key_ok_i = 1'b0;
  logic       term_req_i = 1'b0;
  logic [2:0] phase_o;
  logic       tk_void_o, err_o;
  logic       perm_full_mem_o, perm_os_patch_o, perm_file_struct_o, perm_personal_o, perm_use_o;

  lifecycle_ctrl u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  logic [2:0] m_ph;
  logic m_auth, m_tk;

  function automatic logic [10:0] pack(input logic [2:0] p, input logic a, input logic e,
                                       input logic t);
    return {p, p == 3'd0, p == 3'd1 && a, p == 3'd2 && a, p == 3'd3, p == 3'd4, e, t};
  endfunction

  task automatic do_reset(input logic [2:0] nv, input logic nvtk, input string tag);
    @(negedge clk);
    rst_n = 1'b0; nv_phase_i = nv; nv_tk_void_i = nvtk;
    adv_req_i = 0; key_ok_i = 0; term_req_i = 0;
    @(posedge clk);
    m_ph = (nv <= 3'd4) ? nv : 3'd7;
    m_auth = 0;
    m_tk = nvtk | (m_ph > 3'd2);
    #1; exp_q.push_back(pack(m_ph, m_auth, 1'b0, m_tk)); tag_q.push_back(tag);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic adv, input logic [2:0] tgt, input logic key, input logic term,
                      input string tag);
    logic [2:0] nph;
    logic e;
    @(negedge clk);
    adv_req_i = adv; adv_target_i = tgt; key_ok_i = key; term_req_i = term;
    nph = m_ph; e = 0;
    if (term) nph = 3'd7;
    else if (adv) begin
      if (key && tgt == m_ph + 3'd1 && m_ph <= 3'd3) begin
        nph = m_ph + 3'd1;
        if (m_ph == 3'd2) m_tk = 1;
      end else e = 1;
    end
    if (nph != m_ph) m_auth = 0;
    else if (key && (m_ph == 3'd1 || (m_ph == 3'd2 && !m_tk))) m_auth = 1;
    m_ph = nph;
    @(posedge clk);
    #1; exp_q.push_back(pack(m_ph, m_auth, e, m_tk)); tag_q.push_back(tag);
    @(negedge clk);
    adv_req_i = 0; key_ok_i = 0; term_req_i = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [10:0] got, exp;
      string t;
      exp = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {phase_o, perm_full_mem_o, perm_os_patch_o, perm_file_struct_o,
             perm_personal_o, perm_use_o, err_o, tk_void_o};
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s: got %b expected %b (phase,full,os,fs,pd,use,err,tk)", t, got, exp);
      end
    end
  end

  initial begin
    do_reset(3'd0, 1'b0, "R1");
    step(1, 3'd2, 1, 0, "R3");
    step(1, 3'd1, 0, 0, "R3");
    step(1, 3'd1, 1, 0, "R2");
    step(0, 3'd0, 0, 0, "R6");
    step(0, 3'd0, 1, 0, "R6");
    step(1, 3'd0, 1, 0, "R5");
    step(1, 3'd2, 1, 0, "R2");
    step(0, 3'd0, 1, 0, "R7");
    step(1, 3'd3, 1, 0, "R8");
    step(0, 3'd0, 0, 0, "R9");
    do_reset(3'd2, 1'b1, "R8");
    step(0, 3'd0, 1, 0, "R8");
    do_reset(3'd2, 1'b0, "R1");
    step(0, 3'd0, 1, 0, "R7");
    step(0, 3'd0, 0, 1, "R10");
    step(1, 3'd0, 1, 0, "R3");
    step(0, 3'd0, 0, 1, "R4");
    do_reset(3'd5, 1'b0, "R1");
    do_reset(3'd6, 1'b0, "R1");
    do_reset(3'd3, 1'b0, "R8");
    step(1, 3'd4, 1, 0, "R9");
    step(1, 3'd5, 1, 0, "R3");
    step(1, 3'd5, 1, 1, "R4");
    do_reset(3'd1, 1'b0, "R1");
    step(1, 3'd2, 1, 1, "R4");
    do_reset(3'd0, 1'b0, "R1");
    step(0, 3'd0, 0, 1, "R10");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule